// File: doc/BRIEF.md
# RTC register bank with update-inhibit

This block keeps the sixteen software-visible bytes of a real-time clock: six BCD time and calendar bytes, one control byte and nine general storage bytes. Behind the six time bytes sits a separate set of time counters that advance on a 1 Hz tick. After each tick the block copies the whole counter set into the visible time bytes in a single cycle. Software therefore never sees a half-updated time.

Bit 3 of the control byte is an update inhibit. While it is set, the visible time bytes stay frozen and the counters keep running. Software can take a stable snapshot across a second boundary, or it can write new BCD values. If any time byte was written during the freeze, clearing the inhibit loads the visible time bytes into the counters. Bit 1 of the control byte is a stop control that can halt the counters while the system runs from battery. A power-fail input blocks every register write.

The register port is synchronous for writes and combinational for reads. The inputs are one 1 Hz tick pulse, a power-fail flag and a battery-mode flag.

Top module: `rtc_shadow_bank`

## Requirements
- R1: The 16 bytes have these addresses: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month, 5 year, 0xE control; all others are storage. `rdata_o` shows the byte at `addr_i` in the same cycle.
- R2: The tick has this timing: a tick sampled on an edge advances the counters on that edge. On the following edge all six visible time bytes take the new counter value together.
- R3: The update inhibit is control bit 3. If it is 1 when a tick is sampled, no copy into the visible time bytes follows.
- R4: The counters keep advancing while the inhibit is set. Clearing the inhibit without any time-byte write leaves them untouched, so the next copy shows the time advanced by every tick.
- R5: If the inhibit is written to 1 in the cycle between a tick and its copy, that copy still completes.
- R6: Suppose a time byte is written while the inhibit is 1. The control write that clears the inhibit then loads all six visible time bytes into the counters. The next tick advances from those values.
- R7: The stop control is control bit 1. With `batt_mode_i` high and stop 0, ticks do not advance the counters. With stop 1, or with `batt_mode_i` low, the counters advance.
- R8: While `power_fail_i` is high, writes to any byte are ignored.
- R9: A time-byte write while the inhibit is 0 is readable at once. The next copy overwrites it, and it never reaches the counters.
- R10: The counters roll over as follows: seconds and minutes after 59 and hours after 23. The day of month rolls over after the month's last day, with February having 29 days when the year is divisible by 4. The month rolls over after 12 and the year after 99. The day and month restart at 01 and the other fields restart at 00.
- R11: Reset sets the time to 00:00:00, day 01, month 01, year 00. The control and storage bytes reset to 0.
- R12: Storage bytes keep the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 1 Hz pulse |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| power_fail_i | input | 1 | Blocks all writes |
| batt_mode_i | input | 1 | Running from battery |

## Verification
The assertions take for granted that tick pulses never fall on consecutive cycles. They also assume that every value loaded into the time counters is valid BCD within its field's range, so that seconds can never exceed 59. The stimulus meets both conditions. Ticks are issued only through a task that leaves idle cycles after each pulse. Every random time-byte write is drawn from the legal range of its field. Random day values stop at 28, and the later days appear only in directed month-end cases.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NUM_TIME = 6;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                     hour: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(logic [7:0] b);
    if (b[3:0] == 4'h9) return {b[7:4] + 4'h1, 4'h0};
    return {b[7:4], b[3:0] + 4'h1};
  endfunction

  function automatic logic is_leap(logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};  // tens*10 == tens*2 mod 4
    return s[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] last_day(logic [7:0] m, logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t time_next(rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec != 8'h59) n.sec = bcd_inc(t.sec);
    else begin
      n.sec = 8'h00;
      if (t.min != 8'h59) n.min = bcd_inc(t.min);
      else begin
        n.min = 8'h00;
        if (t.hour != 8'h23) n.hour = bcd_inc(t.hour);
        else begin
          n.hour = 8'h00;
          if (t.date != last_day(t.month, t.year)) n.date = bcd_inc(t.date);
          else begin
            n.date = 8'h01;
            if (t.month != 8'h12) n.month = bcd_inc(t.month);
            else begin
              n.month = 8'h01;
              n.year  = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
            end
          end
        end
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t time_o
);
  rtc_time_t time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_q <= TIME_RST;
    else if (load_i) time_q <= load_val_i;  // commit beats a tick
    else if (step_i) time_q <= time_next(time_q);
  end

  assign time_o = time_q;
endmodule

// File: rtl/rtc_xfer_ctrl.sv
module rtc_xfer_ctrl #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 14,
  parameter int unsigned INH_BIT   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              inhibit_i,
  input  logic              wr_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              busy_o,
  output logic              commit_o
);
  localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] TimeA = ADDR_W'(rtc_pkg::NUM_TIME);

  logic busy_q, dirty_q, wr_ctrl, wr_time, clr_inh;

  assign wr_ctrl  = wr_ok_i && (addr_i == CtrlA);
  assign wr_time  = wr_ok_i && (addr_i < TimeA);
  assign clr_inh  = wr_ctrl && !wdata_i[INH_BIT];
  assign commit_o = clr_inh && inhibit_i && dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      busy_q <= tick_i && !inhibit_i;  // latched: a later inhibit cannot cancel it
      if (clr_inh)                       dirty_q <= 1'b0;
      else if (wr_time && inhibit_i)     dirty_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 14,
  parameter int unsigned INH_BIT   = 3,
  parameter int unsigned STOP_BIT  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  rtc_time_t         time_i,
  input  logic              wr_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output rtc_time_t         shadow_o,
  output logic [7:0]        ctrl_o,
  output logic              inhibit_o,
  output logic              stop_o
);
  localparam int unsigned NUM_REGS = 1 << ADDR_W;

  logic [7:0] regs [NUM_REGS];
  logic [NUM_TIME*8-1:0] time_vec, rst_vec;

  assign time_vec = time_i;
  assign rst_vec  = TIME_RST;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] q;
    logic       sel;
    assign sel = wr_ok_i && (addr_i == ADDR_W'(i));
    if (i < NUM_TIME) begin : g_time
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= rst_vec[8*i +: 8];
        else if (xfer_i) q <= time_vec[8*i +: 8];
        else if (sel)    q <= wdata_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= 8'h00;
        else if (sel) q <= wdata_i;
      end
    end
    assign regs[i] = q;
  end

  for (genvar j = 0; j < NUM_TIME; j++) begin : g_pack
    assign shadow_o[8*j +: 8] = regs[j];
  end

  assign rdata_o   = regs[addr_i];
  assign ctrl_o    = regs[CTRL_ADDR];
  assign inhibit_o = ctrl_o[INH_BIT];
  assign stop_o    = ctrl_o[STOP_BIT];
endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 14,
  parameter int unsigned INH_BIT   = 3,
  parameter int unsigned STOP_BIT  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              power_fail_i,
  input  logic              batt_mode_i
);
  logic      wr_ok, xfer_busy, commit, inhibit, stop, step;
  logic [7:0] ctrl_byte;
  rtc_time_t cnt_time, shd_time;

  assign wr_ok = we_i && !power_fail_i;
  assign step  = tick_i && (!batt_mode_i || stop);

  rtc_time_counter u_cnt (
    .clk_i, .rst_ni,
    .step_i     (step),
    .load_i     (commit),
    .load_val_i (shd_time),
    .time_o     (cnt_time)
  );

  rtc_xfer_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .INH_BIT(INH_BIT)) u_xfer (
    .clk_i, .rst_ni,
    .tick_i,
    .inhibit_i (inhibit),
    .wr_ok_i   (wr_ok),
    .addr_i,
    .wdata_i,
    .busy_o    (xfer_busy),
    .commit_o  (commit)
  );

  rtc_shadow_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .INH_BIT(INH_BIT),
                    .STOP_BIT(STOP_BIT)) u_shd (
    .clk_i, .rst_ni,
    .xfer_i    (xfer_busy),
    .time_i    (cnt_time),
    .wr_ok_i   (wr_ok),
    .addr_i,
    .wdata_i,
    .rdata_o,
    .shadow_o  (shd_time),
    .ctrl_o    (ctrl_byte),
    .inhibit_o (inhibit),
    .stop_o    (stop)
  );
endmodule

// File: rtl/rtc_shadow_bank_chk.sv
module rtc_shadow_bank_chk #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              power_fail_i,
  input logic              batt_mode_i,
  input logic              wr_ok,
  input logic              xfer_busy,
  input logic              commit,
  input logic              inhibit,
  input logic              stop,
  input logic [7:0]        ctrl_byte,
  input logic [47:0]       cnt_time,
  input logic [47:0]       shd_time
);
  localparam logic [ADDR_W-1:0] TimeA = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_ADDR);

  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit && !xfer_busy && !(wr_ok && addr_i < TimeA)) |=> $stable(shd_time));

  a_r5_busy_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_busy |-> $past(tick_i && !inhibit));

  a_r2_copy_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_busy |=> (shd_time == $past(cnt_time)));

  a_r6_commit_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (cnt_time == $past(shd_time)));

  a_r7_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (batt_mode_i && !stop && !commit) |=> $stable(cnt_time));

  a_r8_pf_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (power_fail_i && we_i && addr_i == CtrlA) |=> $stable(ctrl_byte));

  a_r10_sec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_time[7:0] <= 8'h59));
endmodule

bind rtc_shadow_bank rtc_shadow_bank_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) chk_i (
  .clk_i, .rst_ni, .tick_i, .we_i, .addr_i, .power_fail_i, .batt_mode_i,
  .wr_ok, .xfer_busy, .commit, .inhibit, .stop, .ctrl_byte,
  .cnt_time, .shd_time
);

// File: tb/rtc_shadow_bank_tb_top.sv
`timescale 1ns/1ps
module rtc_shadow_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, we = 1'b0, pf = 1'b0, batt = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int         total = 0, bad = 0;

  logic [7:0] m_shd [16];
  logic [7:0] m_cnt [6];
  bit         m_dirty;

  always #2 clk = ~clk;

  rtc_shadow_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .power_fail_i(pf), .batt_mode_i(batt)
  );

  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] i2b(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int mdays(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_inc();
    int s, mi, h, d, mo, y;
    s = b2i(m_cnt[0]); mi = b2i(m_cnt[1]); h = b2i(m_cnt[2]);
    d = b2i(m_cnt[3]); mo = b2i(m_cnt[4]); y = b2i(m_cnt[5]);
    s++;
    if (s == 60) begin s = 0; mi++; end
    if (mi == 60) begin mi = 0; h++; end
    if (h == 24) begin h = 0; d++; end
    if (d > mdays(mo, y)) begin d = 1; mo++; end
    if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
    m_cnt[0] = i2b(s); m_cnt[1] = i2b(mi); m_cnt[2] = i2b(h);
    m_cnt[3] = i2b(d); m_cnt[4] = i2b(mo); m_cnt[5] = i2b(y);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%0h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  task automatic rd(string req, int a);
    @(negedge clk);
    addr = 4'(a);
    #1 check(req, rdata, m_shd[a]);
  endtask

  task automatic rd_all(string req);
    for (int i = 0; i < 16; i++) rd(req, i);
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (pf) return;
    if (a == 14) begin
      if (!d[3]) begin
        if (m_shd[14][3] && m_dirty)
          for (int k = 0; k < 6; k++) m_cnt[k] = m_shd[k];
        m_dirty = 0;
      end
      m_shd[14] = d;
    end else begin
      if (a < 6 && m_shd[14][3]) m_dirty = 1;
      m_shd[a] = d;
    end
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (!batt || m_shd[14][1]) model_inc();
    if (!m_shd[14][3]) for (int k = 0; k < 6; k++) m_shd[k] = m_cnt[k];
    @(negedge clk);
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                          logic [7:0] d, logic [7:0] mo, logic [7:0] y);
    wr(14, 8'h08);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, d); wr(4, mo); wr(5, y);
    wr(14, 8'h00);
  endtask

  function automatic logic [7:0] rnd_field(int a);
    case (a)
      0, 1:    return i2b(int'($urandom % 60));
      2:       return i2b(int'($urandom % 24));
      3:       return i2b(int'($urandom % 28) + 1);
      4:       return i2b(int'($urandom % 12) + 1);
      default: return i2b(int'($urandom % 100));
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) m_shd[i] = 8'h00;
    m_shd[3] = 8'h01; m_shd[4] = 8'h01;
    for (int k = 0; k < 6; k++) m_cnt[k] = m_shd[k];
    m_dirty = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd_all("R11 reset");
    do_tick();
    rd("R2 tick copy", 0);
    rd_all("R1 map");

    // R12 storage
    wr(7, 8'hA5); wr(15, 8'h3C);
    rd("R12 storage", 7); rd("R12 storage", 15);

    // R10 rollover cases
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99); do_tick(); rd_all("R10 year wrap");
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h04); do_tick(); rd_all("R10 leap feb 29");
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h04); do_tick(); rd_all("R10 leap to mar");
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03); do_tick(); rd_all("R10 nonleap to mar");
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h10); do_tick(); rd_all("R10 30 day month");
    set_time(8'h59, 8'h59, 8'h09, 8'h15, 8'h06, 8'h10); do_tick(); rd_all("R10 hour bcd carry");

    // R6 commit then advance
    set_time(8'h10, 8'h20, 8'h05, 8'h07, 8'h08, 8'h21);
    do_tick(); rd_all("R6 commit");

    // R3/R4 frozen read across ticks, counters still run
    wr(14, 8'h08);
    do_tick(); do_tick(); do_tick();
    rd_all("R3 frozen");
    wr(14, 8'h00);
    do_tick(); rd_all("R4 kept counting");

    // R5 inhibit raised in the cycle between tick and copy
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; we = 1'b1; addr = 4'd14; wdata = 8'h08;
    model_inc();
    for (int k = 0; k < 6; k++) m_shd[k] = m_cnt[k];
    m_shd[14] = 8'h08;
    @(negedge clk);
    we = 1'b0;
    rd_all("R5 in-flight copy");
    do_tick(); rd_all("R5 then frozen");
    wr(14, 8'h00);

    // R9 write with inhibit clear
    wr(0, 8'h33);
    rd("R9 shadow write", 0);
    do_tick(); rd_all("R9 overwritten");

    // R7 stop control
    batt = 1'b1;
    do_tick(); rd_all("R7 halted in battery");
    wr(14, 8'h02);
    do_tick(); rd_all("R7 stop=1 runs");
    wr(14, 8'h00);
    batt = 1'b0;
    do_tick(); rd_all("R7 main power runs");

    // R8 power fail
    pf = 1'b1;
    wr(14, 8'h0A); wr(9, 8'h77); wr(2, 8'h11);
    rd_all("R8 writes ignored");
    pf = 1'b0;

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 10);
      pf   = ($urandom % 10) == 0;
      batt = ($urandom % 4) == 0;
      if (op < 3) do_tick();
      else if (op < 5) begin
        int a;
        a = int'($urandom % 6);
        wr(a, rnd_field(a));
      end else if (op < 7) wr(14, {4'h0, 1'($urandom % 2), 1'b0, 1'($urandom % 2), 1'b0});
      else if (op < 8) begin
        int a;
        a = 6 + int'($urandom % 10);
        if (a == 14) a = 15;
        wr(a, 8'($urandom));
      end else rd("R1 random read", int'($urandom % 16));
    end
    pf = 1'b0; batt = 1'b0;
    wr(14, 8'h00);
    do_tick();
    rd_all("R2 final");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule